// File: doc/BRIEF.md
# Command Stream Opcode Parser

This block reads a stream of 32-bit command words and turns them into register-write transactions. Each write carries a class id, a 12-bit register offset and 32 bits of data. The parser treats a word as a header, decodes the 4-bit opcode in its top nibble, and then takes in as many payload words as that header calls for. It emits one write per payload word, or a single write for an immediate header. Restart and gather headers are not executed. Their decoded fields are reported on a side output, and parsing continues with the next word.

Back-pressure rules:
- **Input and output ports.** Both use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high.
- **Output stage and `in_ready`.** The write port is driven by a single output register. `in_ready` is high exactly when that register is empty or is being drained in the same cycle, so `in_ready` may depend combinationally on `wr_ready`.
- **Stalls.** While `wr_valid` is high and `wr_ready` is low, the write fields stay constant and no input word is taken. No payload word can therefore be lost.
- **Side output.** It has no ready. It is a one-cycle pulse, and its fields are valid only while `side_valid` is high.

Top module: `cmdstream_parser`

## Requirements
- R1: The opcode of a header is word bits 31:28. The codes are: 0 set-class, 1 incrementing write, 2 fixed-offset write, 3 mask write, 4 immediate, 5 restart, 6 gather, 12 wide gather. After reset the class is 0, the next word is parsed as a header, `wr_valid`, `side_valid` and `err_reserved` are 0, and `in_ready` is 1.
- R2: An incrementing header (opcode 1) takes its start offset from bits 27:16 and a count N from bits 15:0. The next N words are written to offset, offset+1, and so on, wrapping modulo 4096.
- R3: A fixed-offset header (opcode 2) takes its offset from bits 27:16 and a count N from bits 15:0. All of the next N words are written to that same offset.
- R4: A mask header (opcode 3) takes its offset from bits 27:16 and a mask from bits 15:0. One payload word follows per set bit, lowest bit first. Each is written to offset plus that bit's index.
- R5: An immediate header (opcode 4) produces exactly one write to offset bits 27:16. Its data is bits 15:0 zero-extended to 32 bits. No payload word is consumed.
- R6: A set-class header (opcode 0) loads the class from bits 15:6 and takes its offset from bits 27:16. Each set bit of the mask in bits 5:0 consumes one payload word, placed as in R4. The new class applies to these payload writes and to every later write.
- R7: Incrementing or fixed-offset headers with count 0, and mask or set-class headers with an empty mask, produce no write. The word that follows is parsed as a header. This includes the no-op word 0x2000_0000.
- R8: Restart, gather and wide-gather headers produce no write and consume no payload. In the cycle after acceptance, `side_valid` pulses with the opcode and with `side_value` set as follows:
  - restart: bits 27:0;
  - gather: bits 13:0;
  - wide gather: bits 27:0.
  For a gather, `side_has_off` equals bit 15, `side_incr` equals bit 15 AND bit 14, and `side_offset` equals bits 27:16 when bit 15 is set and 0 otherwise.
- R9: A header with a reserved opcode (7 to 11, 13 to 15) sets `err_reserved`. The flag stays set until reset. The word is dropped and the next word is parsed as a header. Payload words are never decoded as headers.
- R10: While `wr_valid` is high and `wr_ready` is low, `in_ready` is low and the class, offset and data on the write port stay stable. Every payload word accepted is delivered once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Parser can take a word |
| in_word | input | 32 | Command word |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Write consumer ready |
| wr_class | output | CLASS_W (10) | Class id of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| side_valid | output | 1 | One-cycle pulse for a reported header |
| side_op | output | 4 | Opcode of the reported header |
| side_value | output | 28 | Restart address field or gather count |
| side_offset | output | 12 | Gather offset when present, else 0 |
| side_has_off | output | 1 | Gather offset-present flag |
| side_incr | output | 1 | Gather incrementing-mode flag |
| err_reserved | output | 1 | Sticky reserved-opcode flag |

## Verification
The following are checked on every cycle by assertions:
- the write port holds steady under back-pressure while input is refused;
- an immediate header yields its zero-extended write in the next cycle;
- a mask walk drops exactly one bit per payload word;
- incrementing writes step the offset by one;
- a reserved opcode raises a flag that then stays raised.

Only the bench scenarios can show the remaining behaviour: the exact order and addresses of whole bursts, offset wrap, a class change carried into later writes, silent no-op and zero-count headers, the side-output fields, and a reset in the middle of a burst returning the parser to header parsing with class 0.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int WORD_W    = 32;
  localparam int OP_W      = 4;
  localparam int OFF_W     = 12;
  localparam int LOW_W     = 16;
  localparam int SIDE_W    = 28;
  localparam int SCMASK_W  = 6;
  localparam int CLASS_LSB = 6;
  localparam int CLASS_MAX = 10;
  localparam int GCNT_W    = 14;

  localparam logic [OP_W-1:0] OPC_SETCLASS = 4'd0;
  localparam logic [OP_W-1:0] OPC_INCR     = 4'd1;
  localparam logic [OP_W-1:0] OPC_FIXED    = 4'd2;
  localparam logic [OP_W-1:0] OPC_MASK     = 4'd3;
  localparam logic [OP_W-1:0] OPC_IMM      = 4'd4;
  localparam logic [OP_W-1:0] OPC_RESTART  = 4'd5;
  localparam logic [OP_W-1:0] OPC_GATHER   = 4'd6;
  localparam logic [OP_W-1:0] OPC_WIDE     = 4'd12;

  typedef enum logic [1:0] {WM_INCR, WM_FIXED, WM_MASK} wmode_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [SIDE_W-1:0] value;
    logic [OFF_W-1:0]  off;
    logic              has_off;
    logic              incr;
  } side_t;
endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
  import cmdp_pkg::*;
#(
  parameter int CLASS_W = 10
) (
  input  logic [WORD_W-1:0]  word,
  output logic [OP_W-1:0]    op,
  output logic [OFF_W-1:0]   off,
  output logic [LOW_W-1:0]   low,
  output logic [CLASS_W-1:0] cls,
  output logic [LOW_W-1:0]   sc_mask,
  output logic               is_reserved,
  output side_t              side
);
  localparam int OP_LSB  = WORD_W - OP_W;
  localparam int OFF_LSB = LOW_W;
  localparam int GOFF_BIT = LOW_W - 1;
  localparam int GINC_BIT = LOW_W - 2;

  assign op      = word[OP_LSB +: OP_W];
  assign off     = word[OFF_LSB +: OFF_W];
  assign low     = word[LOW_W-1:0];
  assign cls     = word[CLASS_LSB +: CLASS_W];
  assign sc_mask = {{(LOW_W-SCMASK_W){1'b0}}, word[SCMASK_W-1:0]};

  always_comb begin
    is_reserved = 1'b0;
    side        = '0;
    side.op     = op;
    case (op)
      OPC_SETCLASS, OPC_INCR, OPC_FIXED, OPC_MASK, OPC_IMM: ;
      OPC_RESTART: side.value = word[SIDE_W-1:0];
      OPC_WIDE:    side.value = word[SIDE_W-1:0];
      OPC_GATHER: begin
        side.value   = {{(SIDE_W-GCNT_W){1'b0}}, word[GCNT_W-1:0]};
        side.has_off = word[GOFF_BIT];
        side.incr    = word[GOFF_BIT] & word[GINC_BIT];
        side.off     = word[GOFF_BIT] ? word[OFF_LSB +: OFF_W] : '0;
      end
      default: is_reserved = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmdp_lowbit.sv
module cmdp_lowbit #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  first,
  output logic [IW-1:0] idx
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_scan
      assign seen[g+1] = seen[g] | vec[g];
      assign first[g]  = vec[g] & ~seen[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/cmdp_wr_slice.sv
module cmdp_wr_slice #(
  parameter int CLASS_W = 10,
  parameter int OFF_W   = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CLASS_W-1:0] ld_cls,
  input  logic [OFF_W-1:0]   ld_off,
  input  logic [DATA_W-1:0]  ld_data,
  output logic               free,
  output logic               valid,
  input  logic               ready,
  output logic [CLASS_W-1:0] cls,
  output logic [OFF_W-1:0]   off,
  output logic [DATA_W-1:0]  data
);
  assign free = ~valid | ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cls   <= '0;
      off   <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cls   <= ld_cls;
      off   <= ld_off;
      data  <= ld_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(cls) && $stable(off) && $stable(data))); // R10
endmodule

// File: rtl/cmdstream_parser.sv
module cmdstream_parser
  import cmdp_pkg::*;
#(
  parameter int CLASS_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_word,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [CLASS_W-1:0] wr_class,
  output logic [11:0]        wr_offset,
  output logic [31:0]        wr_data,
  output logic               side_valid,
  output logic [3:0]         side_op,
  output logic [27:0]        side_value,
  output logic [11:0]        side_offset,
  output logic               side_has_off,
  output logic               side_incr,
  output logic               err_reserved
);
  localparam int IDX_W = $clog2(LOW_W);

  typedef enum logic {ST_HDR, ST_PAY} st_e;

  st_e                st_q, st_d;
  wmode_e             mode_q, mode_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic [LOW_W-1:0]   cnt_q, cnt_d;
  logic [LOW_W-1:0]   mask_q, mask_d;
  logic [CLASS_W-1:0] cls_q, cls_d;
  logic               err_q, err_d;

  logic [OP_W-1:0]    dec_op;
  logic [OFF_W-1:0]   dec_off;
  logic [LOW_W-1:0]   dec_low;
  logic [CLASS_W-1:0] dec_cls;
  logic [LOW_W-1:0]   dec_scmask;
  logic               dec_reserved;
  side_t              dec_side;

  logic [LOW_W-1:0]   mask_first;
  logic [IDX_W-1:0]   mask_idx;
  logic [LOW_W-1:0]   mask_rest;

  logic               ld;
  logic [OFF_W-1:0]   ld_off;
  logic [WORD_W-1:0]  ld_data;
  logic               slice_free;
  logic               acc;

  side_t              side_q;
  logic               side_v_q;
  logic               side_ld;

  cmdp_hdr_decode #(.CLASS_W(CLASS_W)) u_dec (
    .word        (in_word),
    .op          (dec_op),
    .off         (dec_off),
    .low         (dec_low),
    .cls         (dec_cls),
    .sc_mask     (dec_scmask),
    .is_reserved (dec_reserved),
    .side        (dec_side)
  );

  cmdp_lowbit #(.W(LOW_W)) u_low (
    .vec   (mask_q),
    .first (mask_first),
    .idx   (mask_idx)
  );

  cmdp_wr_slice #(.CLASS_W(CLASS_W), .OFF_W(OFF_W), .DATA_W(WORD_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .ld_cls  (cls_q),
    .ld_off  (ld_off),
    .ld_data (ld_data),
    .free    (slice_free),
    .valid   (wr_valid),
    .ready   (wr_ready),
    .cls     (wr_class),
    .off     (wr_offset),
    .data    (wr_data)
  );

  assign in_ready  = slice_free;
  assign acc       = in_valid & slice_free;
  assign mask_rest = mask_q & ~mask_first;

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    off_d   = off_q;
    cnt_d   = cnt_q;
    mask_d  = mask_q;
    cls_d   = cls_q;
    err_d   = err_q;
    ld      = 1'b0;
    ld_off  = off_q;
    ld_data = in_word;
    side_ld = 1'b0;
    if (acc) begin
      if (st_q == ST_HDR) begin
        case (dec_op)
          OPC_SETCLASS: begin
            cls_d  = dec_cls;
            off_d  = dec_off;
            mask_d = dec_scmask;
            mode_d = WM_MASK;
            if (dec_scmask != '0) st_d = ST_PAY;
          end
          OPC_INCR, OPC_FIXED: begin
            off_d  = dec_off;
            cnt_d  = dec_low;
            mode_d = (dec_op == OPC_INCR) ? WM_INCR : WM_FIXED;
            if (dec_low != '0) st_d = ST_PAY;
          end
          OPC_MASK: begin
            off_d  = dec_off;
            mask_d = dec_low;
            mode_d = WM_MASK;
            if (dec_low != '0) st_d = ST_PAY;
          end
          OPC_IMM: begin
            ld      = 1'b1;
            ld_off  = dec_off;
            ld_data = {{(WORD_W-LOW_W){1'b0}}, dec_low};
          end
          OPC_RESTART, OPC_GATHER, OPC_WIDE: side_ld = 1'b1;
          default: err_d = err_q | dec_reserved;
        endcase
      end else begin
        ld = 1'b1;
        if (mode_q == WM_MASK) begin
          ld_off = off_q + OFF_W'(mask_idx);
          mask_d = mask_rest;
          if (mask_rest == '0) st_d = ST_HDR;
        end else begin
          ld_off = off_q;
          cnt_d  = cnt_q - 1'b1;
          if (mode_q == WM_INCR) off_d = off_q + 1'b1;
          if (cnt_q == LOW_W'(1)) st_d = ST_HDR;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_HDR;
      mode_q   <= WM_INCR;
      off_q    <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
      cls_q    <= '0;
      err_q    <= 1'b0;
      side_v_q <= 1'b0;
      side_q   <= '0;
    end else begin
      st_q     <= st_d;
      mode_q   <= mode_d;
      off_q    <= off_d;
      cnt_q    <= cnt_d;
      mask_q   <= mask_d;
      cls_q    <= cls_d;
      err_q    <= err_d;
      side_v_q <= side_ld;
      if (side_ld) side_q <= dec_side;
    end
  end

  assign side_valid   = side_v_q;
  assign side_op      = side_q.op;
  assign side_value   = side_q.value;
  assign side_offset  = side_q.off;
  assign side_has_off = side_q.has_off;
  assign side_incr    = side_q.incr;
  assign err_reserved = err_q;

  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR && acc && dec_reserved) |=> err_reserved); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_reserved |=> err_reserved); // R9
  AST_IMM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR && acc && dec_op == OPC_IMM) |=>
      (wr_valid && wr_data == {16'h0, $past(in_word[15:0])})); // R5
  AST_MASK_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY && mode_q == WM_MASK && acc && $countones(mask_q) > 1) |=>
      ($countones(mask_q) == $countones($past(mask_q)) - 1)); // R4
  AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY && mode_q == WM_INCR && acc && cnt_q > 1) |=>
      (off_q == $past(off_q) + 1'b1)); // R2
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !in_ready); // R10
endmodule

// File: tb/cmdstream_parser_bench.sv
module cmdstream_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [9:0]  wr_class;
  logic [11:0] wr_offset;
  logic [31:0] wr_data;
  logic        side_valid;
  logic [3:0]  side_op;
  logic [27:0] side_value;
  logic [11:0] side_offset;
  logic        side_has_off;
  logic        side_incr;
  logic        err_reserved;

  int nchk = 0;
  int nerr = 0;
  int nobs = 0;
  logic [53:0] obs [0:63];

  always #5 clk = ~clk;

  cmdstream_parser u_cmdstream_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_class(wr_class), .wr_offset(wr_offset),
    .wr_data(wr_data), .side_valid(side_valid), .side_op(side_op), .side_value(side_value),
    .side_offset(side_offset), .side_has_off(side_has_off), .side_incr(side_incr),
    .err_reserved(err_reserved)
  );

  localparam int NSTIM = 21;
  localparam int NEXP  = 14;
  localparam logic [31:0] STIM [0:NSTIM-1] = '{
    32'h1010_0003, 32'h1111_0001, 32'h7000_0001, 32'h1111_0003,
    32'h2020_0002, 32'h2222_0001, 32'h2222_0002,
    32'h3030_8005, 32'h3333_0001, 32'h3333_0002, 32'h3333_0003,
    32'h4040_BEEF, 32'h2000_0000, 32'h1050_0000,
    32'h0100_0A85, 32'h4444_0001, 32'h4444_0002,
    32'h4FFF_0001,
    32'h1FFF_0002, 32'h5555_0001, 32'h5555_0002
  };
  localparam logic [53:0] EXPW [0:NEXP-1] = '{
    {10'h000, 12'h010, 32'h1111_0001}, {10'h000, 12'h011, 32'h7000_0001},
    {10'h000, 12'h012, 32'h1111_0003},
    {10'h000, 12'h020, 32'h2222_0001}, {10'h000, 12'h020, 32'h2222_0002},
    {10'h000, 12'h030, 32'h3333_0001}, {10'h000, 12'h032, 32'h3333_0002},
    {10'h000, 12'h03F, 32'h3333_0003},
    {10'h000, 12'h040, 32'h0000_BEEF},
    {10'h02A, 12'h100, 32'h4444_0001}, {10'h02A, 12'h102, 32'h4444_0002},
    {10'h02A, 12'hFFF, 32'h0000_0001},
    {10'h02A, 12'hFFF, 32'h5555_0001}, {10'h02A, 12'h000, 32'h5555_0002}
  };

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready && nobs < 64) begin
      obs[nobs] = {wr_class, wr_offset, wr_data};
      nobs = nobs + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset wr_valid", wr_valid, 0);
    chk("R1 reset in_ready", in_ready, 1);
    chk("R1 reset err", err_reserved, 0);
    chk("R1 reset side_valid", side_valid, 0);
    @(posedge clk); #2;

    for (int i = 0; i < NSTIM; i++) send(STIM[i]);
    idle(3);
    // R7: no-op and zero count give nothing extra; R9: payload not decoded
    chk("R7 table write count", nobs, NEXP);
    chk("R9 payload never decoded", err_reserved, 0);
    for (int i = 0; i < NEXP; i++)
      chk($sformatf("table write %0d (R2 R3 R4 R5 R6)", i), obs[i], EXPW[i]);

    // R10 back-pressure
    wr_ready = 1'b0;
    send(32'h1060_0002);
    send(32'h6666_0001);
    in_valid = 1'b1;
    in_word  = 32'h6666_0002;
    repeat (3) @(negedge clk);
    chk("R10 in_ready low under stall", in_ready, 0);
    chk("R10 wr_valid held", wr_valid, 1);
    chk("R10 data stable", {wr_offset, wr_data}, {12'h060, 32'h6666_0001});
    @(posedge clk); #2;
    wr_ready = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0;
    idle(3);
    chk("R10 count after stall", nobs, NEXP + 2);
    chk("R10 first after stall", obs[NEXP], {10'h02A, 12'h060, 32'h6666_0001});
    chk("R10 second after stall", obs[NEXP+1], {10'h02A, 12'h061, 32'h6666_0002});

    // R8 side output
    base = nobs;
    send(32'h5123_4567);
    @(negedge clk);
    chk("R8 restart pulse", side_valid, 1);
    chk("R8 restart fields", {side_op, side_value}, {4'd5, 28'h123_4567});
    @(negedge clk);
    chk("R8 pulse one cycle", side_valid, 0);
    @(posedge clk); #2;
    send(32'h6ABC_C123);
    @(negedge clk);
    chk("R8 gather pulse", side_valid, 1);
    chk("R8 gather fields", {side_op, side_value, side_offset, side_has_off, side_incr},
        {4'd6, 28'h000_0123, 12'hABC, 1'b1, 1'b1});
    @(posedge clk); #2;
    send(32'h6DEF_0042);
    @(negedge clk);
    chk("R8 gather no offset", {side_value, side_offset, side_has_off, side_incr},
        {28'h000_0042, 12'h000, 1'b0, 1'b0});
    @(posedge clk); #2;
    send(32'hC0AB_CDEF);
    @(negedge clk);
    chk("R8 wide gather fields", {side_op, side_value}, {4'd12, 28'h0AB_CDEF});
    @(posedge clk); #2;
    chk("R8 no write from side headers", nobs, base);
    send(32'h4071_0009);
    idle(2);
    chk("R8 next word is header", obs[base], {10'h02A, 12'h071, 32'h0000_0009});

    // R9 reserved opcode
    base = nobs;
    send(32'h9000_0000);
    @(negedge clk);
    chk("R9 reserved sets flag", err_reserved, 1);
    @(posedge clk); #2;
    send(32'h4072_000A);
    idle(2);
    chk("R9 flag sticky", err_reserved, 1);
    chk("R9 resumes at header", obs[base], {10'h02A, 12'h072, 32'h0000_000A});

    // R1 reset mid-burst
    send(32'h1080_0005);
    send(32'h8888_0001);
    idle(2);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clears err", err_reserved, 0);
    chk("R1 reset clears wr_valid", wr_valid, 0);
    @(posedge clk); #2;
    base = nobs;
    send(32'h4090_0007);
    idle(2);
    chk("R1 header state and class 0 after reset", obs[base], {10'h000, 12'h090, 32'h0000_0007});

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule